// File: doc/BRIEF.md
# Dual-Lane Complex Sum and Difference Stage

This block is a radix-2 style butterfly without twiddle factors. On every clock where the enable input is high it accepts two complex samples, a left one and a right one. Some fixed number of enabled cycles later it presents their sum on the left output and their difference on the right output. Each output component is one bit wider than an input component, so neither result can overflow.

A frame marker travels beside the data through a shift chain of the same depth. The output marker therefore rises on exactly the cycle that shows the results of the tagged input pair. The stage is meant to sit inside a streaming transform pipeline, where the marker tells the next stage where a frame begins.

The data path has no back-pressure. The enable input is the only flow control: a high enable means the pair is accepted and the whole pipeline advances one step. A low enable freezes every register, including the marker chain. Nothing waits for a ready signal, and nothing is dropped while the enable is low.

Top module: `csd_pair_stage`

## Requirements
- R1: Each input word holds one complex value in two's complement, with the real part in bits [2*CW-1:CW] and the imaginary part in bits [CW-1:0] (CW = 16 by default). Each output word uses the same order with components of CW+1 bits: real in [2*CW+1:CW+1], imaginary in [CW:0].
- R2: Per component, the left output equals left input plus right input. Both inputs are sign-extended to CW+1 bits before the addition.
- R3: Per component, the right output equals left input minus right input. Both inputs are sign-extended to CW+1 bits before the subtraction.
- R4: The results of an accepted pair appear after exactly LAT enabled clock edges (LAT = 2 by default, LAT >= 1). Until then the outputs keep their previous contents.
- R5: While the enable is low, the data inputs and the input marker are ignored, and both data outputs and the output marker hold their values.
- R6: The output marker is high exactly while the outputs show the results of a pair that was accepted with the input marker high. It follows the same LAT-cycle path as the data.
- R7: Synchronous reset clears the data outputs to zero and empties the marker chain. After reset, the output marker stays low until a marked pair has been accepted and has travelled the full latency.
- R8: Extreme operands give exact results with no wrap. For example, 32767 + 32767 = 65534 and -32768 - 32767 = -65535 in the 17-bit outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Enable: accept a pair and advance the pipeline |
| i_sync | input | 1 | Frame marker for the pair presented this cycle |
| i_left | input | 2*CW | Left complex sample, real part above imaginary part |
| i_right | input | 2*CW | Right complex sample, real part above imaginary part |
| o_left | output | 2*(CW+1) | Sum, left plus right |
| o_right | output | 2*(CW+1) | Difference, left minus right |
| o_sync | output | 1 | Marker aligned with the outputs |

## Verification
The embedded properties assume three things about the inputs:
- Reset is high before the first clock edge.
- The enable and marker inputs are never unknown once reset is released.
- Every data word is fully driven on enabled cycles.

The sum-difference parity checks rest on that last point. The bench drives reset from time zero and changes every input only on falling edges. While the enable is low it presents garbage data and a raised marker, to show that these values never enter the pipeline.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Default component width and pipeline depth for the stage.
  localparam int unsigned CSD_COMP_W = 16;
  localparam int unsigned CSD_LAT    = 2;

  // Component position inside a packed complex word: imaginary low, real high.
  typedef enum int unsigned {
    PART_IM = 0,
    PART_RE = 1
  } csd_part_e;

  localparam int unsigned CSD_PARTS = 2;

  function automatic int unsigned csd_part_lsb(input int unsigned part,
                                               input int unsigned width);
    return part * width;
  endfunction

endpackage

// File: rtl/csd_lane.sv
module csd_lane #(
  parameter int unsigned CW = 16
) (
  input  logic [CW-1:0] a,
  input  logic [CW-1:0] b,
  output logic [CW:0]   sum,
  output logic [CW:0]   diff
);

  // Sign-extend by one bit so that the result can never wrap.
  logic [CW:0] a_x;
  logic [CW:0] b_x;

  always_comb begin
    a_x = {a[CW-1], a};
    b_x = {b[CW-1], b};
  end

  // Two independent adders: one for the sum, one for the difference.
  always_comb begin
    sum = a_x + b_x;
  end

  always_comb begin
    diff = a_x - b_x;
  end

endmodule

// File: rtl/csd_delay.sv
module csd_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  // Enabled shift chain; every stage clears on reset.
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)     stg[k] <= '0;
        else if (en) stg[k] <= d;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)     stg[k] <= '0;
        else if (en) stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/csd_pair_stage.sv
module csd_pair_stage #(
  parameter int unsigned CW  = csd_pkg::CSD_COMP_W,
  parameter int unsigned LAT = csd_pkg::CSD_LAT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce,
  input  logic                i_sync,
  input  logic [2*CW-1:0]     i_left,
  input  logic [2*CW-1:0]     i_right,
  output logic [2*(CW+1)-1:0] o_left,
  output logic [2*(CW+1)-1:0] o_right,
  output logic                o_sync
);
  import csd_pkg::*;

  localparam int unsigned OW    = CW + 1;
  localparam int unsigned OUT_W = CSD_PARTS * OW;
  localparam int unsigned BUS_W = 2 * OUT_W;

  logic [OUT_W-1:0] sum_w;
  logic [OUT_W-1:0] diff_w;
  logic [BUS_W-1:0] res_q;

  // One lane per component; the imaginary lane sits in the low slots.
  for (genvar p = 0; p < CSD_PARTS; p++) begin : g_part
    csd_lane #(.CW(CW)) u_lane (
      .a    (i_left [csd_part_lsb(p, CW) +: CW]),
      .b    (i_right[csd_part_lsb(p, CW) +: CW]),
      .sum  (sum_w  [csd_part_lsb(p, OW) +: OW]),
      .diff (diff_w [csd_part_lsb(p, OW) +: OW])
    );
  end

  // The data results and the marker travel through delay chains of equal depth.
  csd_delay #(.W(BUS_W), .DEPTH(LAT)) u_data_pipe (
    .clk (clk),
    .rst (rst),
    .en  (ce),
    .d   ({sum_w, diff_w}),
    .q   (res_q)
  );

  csd_delay #(.W(1), .DEPTH(LAT)) u_sync_pipe (
    .clk (clk),
    .rst (rst),
    .en  (ce),
    .d   (i_sync),
    .q   (o_sync)
  );

  assign o_left  = res_q[BUS_W-1:OUT_W];
  assign o_right = res_q[OUT_W-1:0];

  // Checker state: a marked pair has been accepted since the last reset.
  logic seen_mark_q;
  always_ff @(posedge clk) begin
    if (rst)                 seen_mark_q <= 1'b0;
    else if (ce && i_sync)   seen_mark_q <= 1'b1;
  end

  // Sum and difference of the same operands always share their LSB (R2, R3).
  p_parity_re_r2: assert property (@(posedge clk) disable iff (rst)
    o_left[OW] == o_right[OW]);
  p_parity_im_r3: assert property (@(posedge clk) disable iff (rst)
    o_left[0] == o_right[0]);

  // Frozen pipeline while the enable is low (R5).
  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(o_left) && $stable(o_right)));
  p_sync_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(o_sync));

  // The output marker needs an accepted input marker behind it (R6).
  p_sync_needs_input_r6: assert property (@(posedge clk) disable iff (rst)
    o_sync |-> seen_mark_q);

  // No marker on the cycle after reset (R7).
  p_quiet_after_rst_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !o_sync);

endmodule

// File: tb/sim_csd_pair_stage.sv
`timescale 1ns/1ps
module sim_csd_pair_stage;

  localparam int CW  = 16;
  localparam int OW  = CW + 1;
  localparam int LAT = 2;
  localparam int NV  = 10;

  // Vector layout: {left re, left im, right re, right im, marker}.
  localparam logic [64:0] TAB [NV] = '{
    {16'h0010, 16'h0000, 16'h0000, 16'h0010, 1'b0},
    {16'h0000, 16'h0010, 16'h0010, 16'h0000, 1'b1},
    {16'h0010, 16'hfff0, 16'h0000, 16'h0000, 1'b0},
    {16'h7fff, 16'h7fff, 16'h7fff, 16'h7fff, 1'b0},
    {16'h8000, 16'h8000, 16'h7fff, 16'h8000, 1'b0},
    {16'h8000, 16'h7fff, 16'h8000, 16'h8000, 1'b0},
    {16'h1234, 16'habcd, 16'hfedc, 16'h0001, 1'b0},
    {16'hffff, 16'h0001, 16'h0001, 16'hffff, 1'b1},
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b0},
    {16'h5555, 16'haaaa, 16'h3333, 16'hcccc, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic i_sync = 1'b0;
  logic [2*CW-1:0] i_left = '0;
  logic [2*CW-1:0] i_right = '0;
  logic [2*OW-1:0] o_left;
  logic [2*OW-1:0] o_right;
  logic o_sync;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csd_pair_stage #(.CW(CW), .LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .i_sync(i_sync),
    .i_left(i_left), .i_right(i_right),
    .o_left(o_left), .o_right(o_right), .o_sync(o_sync)
  );

  function automatic logic [2*OW-1:0] expect_res(input logic [15:0] ar, ai,
                                                 br, bi, input bit sub);
    int sr, si;
    sr = sub ? int'($signed(ar)) - int'($signed(br)) : int'($signed(ar)) + int'($signed(br));
    si = sub ? int'($signed(ai)) - int'($signed(bi)) : int'($signed(ai)) + int'($signed(bi));
    return {sr[OW-1:0], si[OW-1:0]};
  endfunction

  task automatic chk(input string req, input logic [2*OW-1:0] act,
                     input logic [2*OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic drive(input logic [64:0] v, input logic en);
    ce      = en;
    i_left  = v[64:33];
    i_right = v[32:1];
    i_sync  = v[0];
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) step();
    // R7: reset state
    chk("R7 reset left", o_left, '0);
    chk("R7 reset right", o_right, '0);
    chk("R7 reset sync", {33'd0, o_sync}, '0);
    rst = 1'b0;

    // Table walk: outputs checked LAT-1 steps after the drive step.
    for (int idx = 0; idx < NV + LAT - 1; idx++) begin
      if (idx < NV) drive(TAB[idx], 1'b1);
      else          drive('0, 1'b1);
      step();
      begin
        int j;
        j = idx - LAT + 1;
        if (j < 0) begin
          chk("R4 not yet", o_left, '0);
          chk("R4 no sync yet", {33'd0, o_sync}, '0);
        end else begin
          logic [15:0] lr, li, rr, ri;
          string tag;
          lr = TAB[j][64:49]; li = TAB[j][48:33];
          rr = TAB[j][32:17]; ri = TAB[j][16:1];
          tag = (j >= 3 && j <= 5) ? "R8" : (j == 0 ? "R1" : "R4");
          chk({tag, " R2 sum"}, o_left, expect_res(lr, li, rr, ri, 1'b0));
          chk({tag, " R3 diff"}, o_right, expect_res(lr, li, rr, ri, 1'b1));
          chk("R6 marker", {33'd0, o_sync}, {33'd0, TAB[j][0]});
        end
      end
    end

    // R5: enable low ignores inputs and holds outputs.
    drive({16'h0100, 16'h0200, 16'h0001, 16'h0002, 1'b0}, 1'b1);
    step();
    drive('0, 1'b1);
    step();
    drive({16'h7777, 16'h8888, 16'h9999, 16'h1111, 1'b1}, 1'b0);
    repeat (4) step();
    chk("R5 hold left", o_left, expect_res(16'h0100, 16'h0200, 16'h0001, 16'h0002, 1'b0));
    chk("R5 hold right", o_right, expect_res(16'h0100, 16'h0200, 16'h0001, 16'h0002, 1'b1));
    chk("R5 hold sync", {33'd0, o_sync}, '0);
    drive('0, 1'b1);
    step();
    chk("R5 ignored data", o_left, '0);
    chk("R5 ignored marker", {33'd0, o_sync}, '0);

    // R7: a marker in flight is flushed by reset, and none appears afterwards.
    drive({16'h0005, 16'h0006, 16'h0007, 16'h0008, 1'b1}, 1'b1);
    step();
    rst = 1'b1;
    drive('0, 1'b1);
    step();
    rst = 1'b0;
    chk("R7 cleared left", o_left, '0);
    chk("R7 cleared sync", {33'd0, o_sync}, '0);
    begin
      logic any_sync;
      any_sync = 1'b0;
      for (int k = 0; k < 12; k++) begin
        drive({16'(k * 37), 16'(k * 91), 16'(k), 16'hffff, 1'b0}, 1'b1);
        step();
        any_sync = any_sync | o_sync;
      end
      chk("R7 no spurious marker", {33'd0, any_sync}, '0);
    end

    // R6: a single marker after reset reaches the output exactly LAT steps later.
    drive({16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b1}, 1'b1);
    step();
    drive('0, 1'b1);
    chk("R6 marker early", {33'd0, o_sync}, '0);
    repeat (LAT - 1) step();
    chk("R6 marker on time", {33'd0, o_sync}, 34'd1);
    chk("R6 marker data", o_left, expect_res(16'h0001, 16'h0001, 16'h0001, 16'h0001, 1'b0));
    step();
    chk("R6 marker one cycle", {33'd0, o_sync}, '0);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

endmodule